// File: doc/BRIEF.md
# Double-Trigger Conversion Sequencer

This block sits between a hardware trigger line and an external successive-approximation conversion engine. The engine is seen only through a handshake: the block sends a one-cycle start pulse with a channel number, and the engine later returns a one-cycle done pulse carrying a 12-bit result. When duplication mode is on, the block converts a single chosen channel twice. Each conversion needs its own trigger. The first result is stored in that channel's own data register. The second result is stored in a separate duplicate register, and only the second conversion can raise the scan-complete interrupt.

A busy flag is high for the whole of each conversion and drops by itself when the conversion finishes. An internal pass flag records whether the next result is the first or the second of the pair. It flips on each completed conversion and returns to "first" whenever duplication mode is switched off. Only the hardware trigger starts work, and it does so only with the hardware trigger enabled and the pin trigger disabled. The software start input is accepted as a port but has no effect.

Top module: `dbl_trig_seq`

## Requirements
- R1: After reset, `busy`, `irq`, `eng_start` and every result register (`ch_data`, `dup_data`) are 0, and the pass flag is "first".
- R2: A `hw_trig` pulse is accepted when all of the following hold: `dup_en`=1, `hw_trig_en`=1, `pin_trig_en`=0, `busy`=0 and `dup_ch` < NUM_CH. On the next cycle, `eng_start` is high for exactly one cycle with `eng_ch` = `dup_ch`, and `busy` is 1.
- R3: A trigger is ignored, with no start pulse and `busy` staying 0, whenever any gating condition of R2 other than `busy` fails. This includes `dup_ch` >= NUM_CH.
- R4: A pulse on `sw_start` never starts a conversion.
- R5: `busy` stays 1 until the cycle in which `eng_done` is sampled, and reads 0 on the cycle after that.
- R6: A first-pass result is written to `ch_data[ch*12 +: 12]` for the latched channel. `dup_data` is left unchanged and no interrupt is raised.
- R7: A second-pass result is written to `dup_data` only, and every channel register is left unchanged.
- R8: After a second-pass result, `irq` is high for exactly one cycle if `irq_en`=1, and stays 0 if `irq_en`=0.
- R9: A trigger that arrives while `busy`=1 produces no start pulse and does not change the pass flag.
- R10: Clearing `dup_en` resets the pass flag, so the next result after re-enabling goes to the channel register.
- R11: An `eng_done` pulse while `busy`=0 changes no register and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dup_en | input | 1 | Duplication mode enable |
| dup_ch | input | 5 | Channel converted in duplication mode |
| hw_trig_en | input | 1 | Hardware trigger enable |
| pin_trig_en | input | 1 | External-pin trigger select (must be 0) |
| irq_en | input | 1 | Scan-complete interrupt enable |
| hw_trig | input | 1 | Hardware trigger pulse |
| sw_start | input | 1 | Software start (ignored) |
| eng_start | output | 1 | One-cycle conversion start to engine |
| eng_ch | output | 5 | Channel for the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 12 | Engine result, valid with `eng_done` |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Scan-complete interrupt pulse |
| ch_data | output | NUM_CH*12 | Per-channel result registers, channel c at bits c*12 +: 12 |
| dup_data | output | 12 | Duplicate result register |

## Verification
An accepted trigger shows up as `eng_start` and `busy` one cycle after the edge that samples it. A done pulse shows up as cleared `busy`, an updated register and a possible `irq` one cycle after its sampling edge, and `irq` is low again one cycle later. The bench drives on falling edges and reads exactly one falling edge after each relevant rising edge. It checks `busy` on every wait cycle of an engine latency that is swept from 1 to 4. Every channel is run with the interrupt both enabled and disabled, and every illegal gating combination and out-of-range channel is tried. The full result vector is compared after each conversion against a model kept in the bench.

// File: rtl/dts_pkg.sv
package dts_pkg;
   typedef enum logic {PASS_FIRST = 1'b0, PASS_SECOND = 1'b1} pass_e;
   localparam int SEL_W = 5;
endpackage

// File: rtl/dts_trig_gate.sv
module dts_trig_gate #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 5
) (
   input  logic            hw_trig,
   input  logic            dup_en,
   input  logic            hw_trig_en,
   input  logic            pin_trig_en,
   input  logic            busy,
   input  logic [CH_W-1:0] dup_ch,
   output logic            accept
);
   localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

   logic ch_ok;
   logic mode_ok;

   assign ch_ok   = {1'b0, dup_ch} < CH_LIMIT;
   assign mode_ok = dup_en & hw_trig_en & ~pin_trig_en;
   assign accept  = hw_trig & mode_ok & ch_ok & ~busy;
endmodule

// File: rtl/dts_ctrl.sv
module dts_ctrl
   import dts_pkg::*;
#(
   parameter int CH_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept,
   input  logic            hw_trig,
   input  logic            dup_en,
   input  logic            irq_en,
   input  logic [CH_W-1:0] dup_ch,
   input  logic            eng_done,
   output logic            eng_start,
   output logic [CH_W-1:0] cur_ch,
   output logic            busy,
   output logic            irq,
   output logic            wr_first,
   output logic            wr_second
);
   pass_e pass_q;
   logic  done_fire;

   assign done_fire = busy & eng_done;
   assign wr_first  = done_fire & (pass_q == PASS_FIRST);
   assign wr_second = done_fire & (pass_q == PASS_SECOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_start <= 1'b0;
         busy      <= 1'b0;
         cur_ch    <= '0;
         irq       <= 1'b0;
         pass_q    <= PASS_FIRST;
      end else begin
         eng_start <= accept;
         irq       <= wr_second & irq_en;
         if (accept) begin
            busy   <= 1'b1;
            cur_ch <= dup_ch;
         end else if (done_fire) begin
            busy <= 1'b0;
         end
         if (!dup_en)
            pass_q <= PASS_FIRST;
         else if (done_fire)
            pass_q <= (pass_q == PASS_FIRST) ? PASS_SECOND : PASS_FIRST;
      end
   end

   assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (eng_start && busy));
   assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !eng_done) |=> busy);
   assert_busy_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done) |=> !busy);
   assert_no_irq_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done && pass_q == PASS_FIRST) |=> !irq);
   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   assert_busy_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && hw_trig) |=> !eng_start);
   assert_idle_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && eng_done) |=> !irq);
endmodule

// File: rtl/dts_result_bank.sv
module dts_result_bank #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 5,
   parameter int RES_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_first,
   input  logic                    wr_second,
   input  logic [CH_W-1:0]         sel,
   input  logic [RES_W-1:0]        result,
   output logic [NUM_CH*RES_W-1:0] ch_data,
   output logic [RES_W-1:0]        dup_data
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic [RES_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_first && sel == CH_W'(g))
            q <= result;
      end
      assign ch_data[g*RES_W +: RES_W] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dup_data <= '0;
      else if (wr_second)
         dup_data <= result;
   end

   assert_dup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_second |=> $stable(dup_data));
   assert_chan_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_first |=> $stable(ch_data));
endmodule

// File: rtl/dbl_trig_seq.sv
module dbl_trig_seq
   import dts_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    dup_en,
   input  logic [SEL_W-1:0]        dup_ch,
   input  logic                    hw_trig_en,
   input  logic                    pin_trig_en,
   input  logic                    irq_en,
   input  logic                    hw_trig,
   input  logic                    sw_start,
   output logic                    eng_start,
   output logic [SEL_W-1:0]        eng_ch,
   input  logic                    eng_done,
   input  logic [RES_W-1:0]        eng_result,
   output logic                    busy,
   output logic                    irq,
   output logic [NUM_CH*RES_W-1:0] ch_data,
   output logic [RES_W-1:0]        dup_data
);
   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= (1 << SEL_W))
         else $error("NUM_CH out of range for the channel field");
      assert (RES_W >= 1)
         else $error("RES_W must be positive");
   end

   logic accept;
   logic wr_first;
   logic wr_second;
   logic sw_unused;

   assign sw_unused = sw_start;

   dts_trig_gate #(.NUM_CH(NUM_CH), .CH_W(SEL_W)) u_gate (
      .hw_trig    (hw_trig),
      .dup_en     (dup_en),
      .hw_trig_en (hw_trig_en),
      .pin_trig_en(pin_trig_en),
      .busy       (busy),
      .dup_ch     (dup_ch),
      .accept     (accept)
   );

   dts_ctrl #(.CH_W(SEL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .hw_trig  (hw_trig),
      .dup_en   (dup_en),
      .irq_en   (irq_en),
      .dup_ch   (dup_ch),
      .eng_done (eng_done),
      .eng_start(eng_start),
      .cur_ch   (eng_ch),
      .busy     (busy),
      .irq      (irq),
      .wr_first (wr_first),
      .wr_second(wr_second)
   );

   dts_result_bank #(.NUM_CH(NUM_CH), .CH_W(SEL_W), .RES_W(RES_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_first (wr_first),
      .wr_second(wr_second),
      .sel      (eng_ch),
      .result   (eng_result),
      .ch_data  (ch_data),
      .dup_data (dup_data)
   );

   assert_sw_start_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_unused && !hw_trig && !busy) |=> !eng_start);
endmodule

// File: tb/test_dbl_trig_seq.sv
`timescale 1ns/1ps
module test_dbl_trig_seq;
   localparam int NCH = 8;
   localparam int RW  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dup_en = 1'b0, hw_trig_en = 1'b0, pin_trig_en = 1'b0, irq_en = 1'b0;
   logic [4:0] dup_ch = '0;
   logic hw_trig = 1'b0, sw_start = 1'b0, eng_done = 1'b0;
   logic [RW-1:0] eng_result = '0;
   logic eng_start, busy, irq;
   logic [4:0] eng_ch;
   logic [NCH*RW-1:0] ch_data;
   logic [RW-1:0] dup_data;

   logic [NCH*RW-1:0] exp_ch = '0;
   logic [RW-1:0] exp_dup = '0;
   bit exp_second = 1'b0;
   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   dbl_trig_seq #(.NUM_CH(NCH), .RES_W(RW)) i_dbl_trig_seq (
      .clk(clk), .rst_n(rst_n), .dup_en(dup_en), .dup_ch(dup_ch),
      .hw_trig_en(hw_trig_en), .pin_trig_en(pin_trig_en), .irq_en(irq_en),
      .hw_trig(hw_trig), .sw_start(sw_start), .eng_start(eng_start),
      .eng_ch(eng_ch), .eng_done(eng_done), .eng_result(eng_result),
      .busy(busy), .irq(irq), .ch_data(ch_data), .dup_data(dup_data)
   );

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic no_start_pulse(input string req);
      @(negedge clk) hw_trig = 1'b1;
      @(negedge clk) hw_trig = 1'b0;
      check(eng_start == 1'b0, req, 128'(eng_start), 0);
      check(busy == 1'b0, req, 128'(busy), 0);
   endtask

   task automatic do_conv(input int ch, input logic [RW-1:0] res,
                          input int lat, input bit inject);
      bit was_second;
      @(negedge clk) hw_trig = 1'b1;
      @(negedge clk) hw_trig = 1'b0;
      check(eng_start == 1'b1, "R2 start", 128'(eng_start), 1);
      check(eng_ch == 5'(ch), "R2 channel", 128'(eng_ch), 128'(ch));
      check(busy == 1'b1, "R2 busy", 128'(busy), 1);
      if (inject) hw_trig = 1'b1;
      for (int i = 0; i < lat; i++) begin
         @(negedge clk) hw_trig = 1'b0;
         check(busy == 1'b1, "R5 busy held", 128'(busy), 1);
         check(eng_start == 1'b0, "R9 no restart", 128'(eng_start), 0);
      end
      eng_done = 1'b1;
      eng_result = res;
      was_second = exp_second;
      if (was_second) exp_dup = res;
      else exp_ch[ch*RW +: RW] = res;
      exp_second = ~exp_second;
      @(negedge clk) eng_done = 1'b0;
      check(busy == 1'b0, "R5 busy cleared", 128'(busy), 0);
      check(ch_data == exp_ch, was_second ? "R7 channel regs" : "R6 channel reg",
            128'(ch_data), 128'(exp_ch));
      check(dup_data == exp_dup, was_second ? "R7 dup reg" : "R6 dup held",
            128'(dup_data), 128'(exp_dup));
      check(irq == (was_second & irq_en), was_second ? "R8 irq" : "R6 no irq",
            128'(irq), 128'(was_second & irq_en));
      @(negedge clk);
      check(irq == 1'b0, "R8 irq single", 128'(irq), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 0 && irq == 0 && eng_start == 0, "R1 flags", {busy, irq, eng_start}, 0);
      check(ch_data == '0 && dup_data == '0, "R1 regs", 128'(ch_data), 0);
      @(negedge clk) rst_n = 1'b1;

      dup_en = 1'b1; hw_trig_en = 1'b1; pin_trig_en = 1'b0; irq_en = 1'b1;
      dup_ch = 5'd0;

      // R11: stray done while idle
      @(negedge clk) begin eng_done = 1'b1; eng_result = 12'hABC; end
      @(negedge clk) eng_done = 1'b0;
      check(ch_data == exp_ch && dup_data == exp_dup, "R11 regs", 128'(ch_data), 128'(exp_ch));
      check(irq == 1'b0, "R11 irq", 128'(irq), 0);

      // R4: software start
      @(negedge clk) sw_start = 1'b1;
      @(negedge clk) sw_start = 1'b0;
      check(eng_start == 1'b0 && busy == 1'b0, "R4 sw start", {eng_start, busy}, 0);

      // R3: every illegal gating combination
      for (int m = 0; m < 8; m++) begin
         if (m != 3'b110) begin
            {dup_en, hw_trig_en, pin_trig_en} = 3'(m);
            no_start_pulse("R3 gating");
         end
      end
      dup_en = 1'b1; hw_trig_en = 1'b1; pin_trig_en = 1'b0;
      exp_second = 1'b0;
      for (int c = NCH; c < 32; c++) begin
         dup_ch = 5'(c);
         no_start_pulse("R3 channel range");
      end

      // Main sweep: every channel, both irq settings, latencies 1..4
      for (int c = 0; c < NCH; c++) begin
         for (int ie = 0; ie < 2; ie++) begin
            logic [RW-1:0] r1;
            r1 = RW'(c * 397 + ie * 91 + 5);
            irq_en = ie[0];
            dup_ch = 5'(c);
            do_conv(c, r1, 1 + (c % 4), (c + ie) % 2 == 1);
            do_conv(c, ~r1, 1 + ((c + 1) % 4), ie == 1);
         end
      end

      // R10: disabling duplication resets the pass flag
      irq_en = 1'b1;
      dup_ch = 5'd2;
      do_conv(2, 12'h123, 2, 1'b0);
      @(negedge clk) dup_en = 1'b0;
      exp_second = 1'b0;
      @(negedge clk) dup_en = 1'b1;
      do_conv(2, 12'h456, 2, 1'b0);
      check(ch_data[2*RW +: RW] == 12'h456, "R10 first after reenable",
            128'(ch_data[2*RW +: RW]), 128'h456);
      do_conv(2, 12'h789, 3, 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule